// File: doc/BRIEF.md
# Battery Isolation Command Detector

This block watches a system while its main supply collapses and decides whether the host deliberately asked for the backup cells to be disconnected. The host asks by parking the chip-enable line at a mid-rail level while the supply falls. The level sensing is done outside the block. The block receives already-digitized flags:
- whether chip-enable reads low,
- whether it sits in the narrow mid-supply band,
- whether it has climbed above a ceiling level,
- whether the supply is below the fail threshold,
- whether the supply is below the lower switchover level.

The detection interval starts when the supply falls through the fail threshold. It ends when the supply falls through the switchover level. Within that interval, chip-enable must dwell in the band for a minimum number of consecutive clock cycles. It must never rise above the ceiling. It must read low at both threshold crossings. When the interval ends with all of this satisfied, the block emits a single-cycle pulse toward the battery selector. A return of the supply above the fail threshold, or a reset, discards everything gathered so far.

Top module: `iso_signal_detect`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `isoValid` is 0.
- R2: A qualifying interval produces `isoValid` = 1 in exactly one cycle: the cycle after the closing cycle. The closing cycle is the one in which `vccBelowSwitch` goes from 0 to 1 while `vccBelowFail` is 1.
- R3: The in-band count covers window cycles only. Window cycles run from the cycle after the opening (where `vccBelowFail` went from 0 to 1) up to and including the closing cycle. `ceInBand` = 1 must hold for `HOLD_CYCLES` consecutive window cycles; `HOLD_CYCLES`-1 is not enough.
- R4: A window cycle with `ceInBand` = 0 restarts the in-band count. Once `HOLD_CYCLES` consecutive cycles have been reached, the condition stays met for the rest of that window.
- R5: `ceAboveCeil` = 1 in any window cycle, including the closing cycle, cancels the pulse for that power-down.
- R6: `ceLow` must be 1 in the opening cycle, or no pulse is issued.
- R7: `ceLow` must be 1 in the closing cycle, or no pulse is issued.
- R8: `vccBelowFail` = 0 during a window discards the window with no pulse. A later window starts its in-band count from zero.
- R9: At most one pulse per power-down: after a window closes, no pulse follows until `vccBelowFail` returns to 0. If both supply flags rise in the same cycle, no window opens and no pulse is issued.
- R10: A supply flag already at 1 when reset is released is not a crossing. A window opens only after `vccBelowFail` has been seen at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vccBelowFail | input | 1 | Supply is below the fail threshold |
| vccBelowSwitch | input | 1 | Supply is below the switchover level |
| ceLow | input | 1 | Chip-enable reads as logic low |
| ceInBand | input | 1 | Chip-enable lies inside the mid-supply band |
| ceAboveCeil | input | 1 | Chip-enable is above the ceiling level |
| isoValid | output | 1 | One-cycle isolation command pulse |

## Verification
Three judgements can land on the closing cycle: the end of the window, a ceiling excursion, and the final in-band cycle that completes the dwell. The bench provokes each on that cycle. A dwell run of exactly `HOLD_CYCLES` that ends on the closing cycle must produce the pulse. A run one short must not. A ceiling flag raised only on the closing cycle must cancel a window whose dwell was already met. Random windows with interleaved band and ceiling patterns are scored by a bench function that scans the drawn pattern for the longest run and any excursion. The pulse count and the cycle of each pulse are both checked.

// File: rtl/isd_pkg.sv
package isd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_DONE = 2'd2
  } winState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic openWin;   // opening cycle: latch entry level, clear gathered state
    logic inWindow;  // a counting cycle inside the window
    logic closeWin;  // closing cycle: judge and fire
    logic clearAll;  // supply recovered: drop everything
  } winStrobe_t;

endpackage

// File: rtl/isd_rise.sv
module isd_rise (
  input  logic clk,
  input  logic rstN,
  input  logic sigIn,
  output logic rise
);
  logic prevQ;

  // resets to 1 so a flag already high after reset is not a crossing
  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= sigIn;
  end

  assign rise = sigIn & ~prevQ;
endmodule

// File: rtl/isd_ctl.sv
module isd_ctl
  import isd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       vccLow,
  input  logic       failEdge,
  input  logic       swEdge,
  output winStrobe_t strobe
);
  winState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (failEdge) begin
          if (swEdge) begin
            stateD = ST_DONE;          // both crossings at once: no window
          end else begin
            strobe.openWin = 1'b1;
            stateD = ST_OPEN;
          end
        end
      end
      ST_OPEN: begin
        if (!vccLow) begin
          strobe.clearAll = 1'b1;
          stateD = ST_IDLE;
        end else if (swEdge) begin
          strobe.closeWin = 1'b1;
          stateD = ST_DONE;
        end else begin
          strobe.inWindow = 1'b1;
        end
      end
      ST_DONE: begin
        if (!vccLow) begin
          strobe.clearAll = 1'b1;
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end
endmodule

// File: rtl/isd_datapath.sv
module isd_datapath
  import isd_pkg::*;
#(
  parameter int HOLD_CYCLES = 140
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vccBelowFail,
  input  logic       vccBelowSwitch,
  input  logic       ceLow,
  input  logic       ceInBand,
  input  logic       ceAboveCeil,
  input  winStrobe_t strobe,
  output logic       failEdge,
  output logic       swEdge,
  output logic       isoValid
);
  localparam int NUM_SUP = 2;
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] RUN_LAST = CW'(HOLD_CYCLES - 1);
  localparam logic [CW-1:0] RUN_CAP  = CW'(HOLD_CYCLES);

  logic [NUM_SUP-1:0] supIn, supRise;
  assign supIn = {vccBelowSwitch, vccBelowFail};

  for (genvar g = 0; g < NUM_SUP; g++) begin : gSupEdge
    isd_rise riseI (
      .clk  (clk),
      .rstN (rstN),
      .sigIn(supIn[g]),
      .rise (supRise[g])
    );
  end

  assign failEdge = supRise[0];
  assign swEdge   = supRise[1];

  logic [CW-1:0] runCnt;
  logic heldQ, abortQ, entryOkQ;
  logic restart, lastBand, bandMet, condsMet;

  assign restart  = strobe.openWin | strobe.clearAll;
  assign lastBand = ceInBand && (runCnt >= RUN_LAST);
  assign bandMet  = heldQ | lastBand;
  assign condsMet = entryOkQ & ~abortQ & ~ceAboveCeil & ceLow & bandMet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (restart) begin
      runCnt <= '0;
    end else if (strobe.inWindow) begin
      if (!ceInBand)           runCnt <= '0;
      else if (runCnt < RUN_CAP) runCnt <= runCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldQ    <= 1'b0;
      abortQ   <= 1'b0;
      entryOkQ <= 1'b0;
    end else if (restart) begin
      heldQ    <= 1'b0;
      abortQ   <= 1'b0;
      entryOkQ <= strobe.openWin & ceLow;
    end else if (strobe.inWindow) begin
      if (lastBand)    heldQ  <= 1'b1;
      if (ceAboveCeil) abortQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) isoValid <= 1'b0;
    else       isoValid <= strobe.closeWin & condsMet;
  end
endmodule

// File: rtl/iso_signal_detect.sv
module iso_signal_detect
  import isd_pkg::*;
#(
  parameter int HOLD_CYCLES = 140
) (
  input  logic clk,
  input  logic rstN,
  input  logic vccBelowFail,
  input  logic vccBelowSwitch,
  input  logic ceLow,
  input  logic ceInBand,
  input  logic ceAboveCeil,
  output logic isoValid
);
  winStrobe_t strobe;
  logic failEdge, swEdge;

  isd_ctl ctlI (
    .clk     (clk),
    .rstN    (rstN),
    .vccLow  (vccBelowFail),
    .failEdge(failEdge),
    .swEdge  (swEdge),
    .strobe  (strobe)
  );

  isd_datapath #(.HOLD_CYCLES(HOLD_CYCLES)) dpI (
    .clk           (clk),
    .rstN          (rstN),
    .vccBelowFail  (vccBelowFail),
    .vccBelowSwitch(vccBelowSwitch),
    .ceLow         (ceLow),
    .ceInBand      (ceInBand),
    .ceAboveCeil   (ceAboveCeil),
    .strobe        (strobe),
    .failEdge      (failEdge),
    .swEdge        (swEdge),
    .isoValid      (isoValid)
  );
endmodule

// File: rtl/iso_signal_detect_chk.sv
module iso_signal_detect_chk (
  input logic clk,
  input logic rstN,
  input logic vccBelowFail,
  input logic vccBelowSwitch,
  input logic ceLow,
  input logic ceAboveCeil,
  input logic isoValid
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    isoValid |=> !isoValid); // R2

  AST_CLOSE_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    isoValid |-> ($past(ceLow) && !$past(ceAboveCeil))); // R7

  AST_NO_PULSE_ON_RECOVERY: assert property (@(posedge clk) disable iff (!rstN)
    !vccBelowFail |=> !isoValid); // R8

  AST_CLOSE_IS_CROSSING: assert property (@(posedge clk) disable iff (!rstN)
    isoValid |-> ($past(vccBelowSwitch) && !$past(vccBelowSwitch, 2))); // R9

  AST_CLOSE_BELOW_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    isoValid |-> $past(vccBelowFail)); // R2
endmodule

bind iso_signal_detect iso_signal_detect_chk chkI (
  .clk           (clk),
  .rstN          (rstN),
  .vccBelowFail  (vccBelowFail),
  .vccBelowSwitch(vccBelowSwitch),
  .ceLow         (ceLow),
  .ceAboveCeil   (ceAboveCeil),
  .isoValid      (isoValid)
);

// File: tb/iso_signal_detect_tb_top.sv
`timescale 1ns/1ps
module iso_signal_detect_tb_top;
  localparam int HOLD = 12;
  localparam int MAXW = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vccBelowFail = 1'b0, vccBelowSwitch = 1'b0;
  logic ceLow = 1'b1, ceInBand = 1'b0, ceAboveCeil = 1'b0;
  logic isoValid;

  int nChecks = 0, nFails = 0;
  int cyc = 0, pulseCnt = 0, lastPulseCyc = -1, closeCyc = 0;
  bit bandPat [MAXW];
  bit ceilPat [MAXW];
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN && isoValid) begin
      pulseCnt++;
      lastPulseCyc = cyc;
    end
  end

  iso_signal_detect #(.HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .rstN(rstN), .vccBelowFail(vccBelowFail),
    .vccBelowSwitch(vccBelowSwitch), .ceLow(ceLow), .ceInBand(ceInBand),
    .ceAboveCeil(ceAboveCeil), .isoValid(isoValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit f, input bit s, input bit l, input bit b, input bit c);
    @(negedge clk);
    vccBelowFail = f; vccBelowSwitch = s; ceLow = l; ceInBand = b; ceAboveCeil = c;
  endtask

  function automatic bit expectValid(input int len, input bit eLow, input bit xLow);
    int run = 0;
    bit met = 1'b0;
    if (!eLow || !xLow) return 1'b0;
    for (int i = 0; i < len; i++) begin
      if (ceilPat[i]) return 1'b0;
      run = bandPat[i] ? run + 1 : 0;
      if (run >= HOLD) met = 1'b1;
    end
    return met;
  endfunction

  task automatic clearPat();
    for (int i = 0; i < MAXW; i++) begin
      bandPat[i] = 1'b0;
      ceilPat[i] = 1'b0;
    end
  endtask

  // one full power-down: idle, opening cycle, len window cycles (last one closes), recovery
  task automatic runWin(input int len, input bit eLow, input bit xLow, input string req);
    bit exp;
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 0, 0);
    pulseCnt = 0;
    drive(1, 0, eLow, 0, 0);
    for (int i = 0; i < len; i++) begin
      drive(1, i == len - 1, (i == len - 1) ? xLow : 1'b1, bandPat[i], ceilPat[i]);
      if (i == len - 1) closeCyc = cyc;
    end
    for (int i = 0; i < 3; i++) drive(1, 1, 1, 0, 0);
    for (int i = 0; i < 2; i++) drive(0, 0, 1, 0, 0);
    exp = expectValid(len, eLow, xLow);
    check(pulseCnt == int'(exp), req, pulseCnt, int'(exp));
    if (exp) check(lastPulseCyc == closeCyc + 1, {req, " timing"}, lastPulseCyc, closeCyc + 1);
  endtask

  initial begin
    int t = 0;
    while (t < 150000 && !done) begin
      @(posedge clk);
      t++;
    end
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (4) @(negedge clk);
    check(isoValid == 1'b0, "R1 during reset", isoValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(isoValid == 1'b0, "R1 after reset", isoValid, 0);

    // R3: exact dwell ending on the close cycle
    clearPat();
    for (int i = 3; i < 3 + HOLD; i++) bandPat[i] = 1'b1;
    runWin(3 + HOLD, 1, 1, "R3 exact dwell at close");
    // R3: one short
    clearPat();
    for (int i = 4; i < 3 + HOLD; i++) bandPat[i] = 1'b1;
    runWin(3 + HOLD, 1, 1, "R3 dwell one short");
    // R4: broken run then full run; held stays after leaving band
    clearPat();
    for (int i = 0; i < HOLD - 1; i++) bandPat[i] = 1'b1;
    for (int i = HOLD; i < 2 * HOLD; i++) bandPat[i] = 1'b1;
    runWin(2 * HOLD + 6, 1, 1, "R4 restart then sticky");
    // R4: broken runs never reaching the dwell
    clearPat();
    for (int i = 0; i < 40; i++) bandPat[i] = (i % HOLD) != HOLD - 2;
    runWin(40, 1, 1, "R4 broken runs");
    // R5: ceiling on close cycle after dwell met
    clearPat();
    for (int i = 0; i < HOLD + 2; i++) bandPat[i] = 1'b1;
    ceilPat[HOLD + 4] = 1'b1;
    runWin(HOLD + 5, 1, 1, "R5 ceiling on close");
    // R5: ceiling mid-window before dwell
    clearPat();
    ceilPat[1] = 1'b1;
    for (int i = 3; i < HOLD + 5; i++) bandPat[i] = 1'b1;
    runWin(HOLD + 6, 1, 1, "R5 ceiling early");
    // R6 / R7
    clearPat();
    for (int i = 0; i < HOLD + 2; i++) bandPat[i] = 1'b1;
    runWin(HOLD + 3, 0, 1, "R6 entry not low");
    runWin(HOLD + 3, 1, 0, "R7 exit not low");
    runWin(HOLD + 3, 1, 1, "R2 plain valid");

    // R8: recovery mid-window, then fresh short window
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 0, 0);
    pulseCnt = 0;
    drive(1, 0, 1, 0, 0);
    for (int i = 0; i < HOLD - 2; i++) drive(1, 0, 1, 1, 0);
    drive(0, 0, 1, 1, 0);
    drive(1, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) drive(1, 0, 1, 1, 0);
    drive(1, 1, 1, 1, 0);
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 0, 0);
    check(pulseCnt == 0, "R8 recovery clears count", pulseCnt, 0);

    // R9: both flags rise together
    pulseCnt = 0;
    drive(1, 1, 1, 1, 0);
    for (int i = 0; i < HOLD + 4; i++) drive(1, 1, 1, 1, 0);
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 0, 0);
    check(pulseCnt == 0, "R9 simultaneous crossings", pulseCnt, 0);

    // R9: second close in the same power-down
    pulseCnt = 0;
    drive(1, 0, 1, 0, 0);
    for (int i = 0; i < HOLD + 1; i++) drive(1, 0, 1, 1, 0);
    drive(1, 1, 1, 1, 0);
    for (int i = 0; i < 3; i++) drive(1, 0, 1, 1, 0);
    for (int i = 0; i < HOLD + 1; i++) drive(1, 0, 1, 1, 0);
    drive(1, 1, 1, 1, 0);
    for (int i = 0; i < 3; i++) drive(1, 1, 1, 0, 0);
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 0, 0);
    check(pulseCnt == 1, "R9 one pulse per power-down", pulseCnt, 1);

    // R10: flags high across reset release
    drive(1, 0, 1, 0, 0);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    pulseCnt = 0;
    for (int i = 0; i < HOLD + 3; i++) drive(1, 0, 1, 1, 0);
    drive(1, 1, 1, 1, 0);
    for (int i = 0; i < 3; i++) drive(1, 1, 1, 0, 0);
    check(pulseCnt == 0, "R10 no crossing after reset", pulseCnt, 0);
    clearPat();
    for (int i = 0; i < HOLD; i++) bandPat[i] = 1'b1;
    runWin(HOLD, 1, 1, "R10 first real crossing");

    // random windows
    for (int n = 0; n < 60; n++) begin
      int len, st, rl;
      bit eLow, xLow;
      clearPat();
      len = HOLD - 4 + int'($urandom % 30);
      for (int i = 0; i < len; i++) bandPat[i] = ($urandom % 3) == 0;
      if (($urandom % 3) != 0) begin
        rl = HOLD - 2 + int'($urandom % 4);
        st = int'($urandom % 10);
        for (int i = st; i < st + rl && i < len; i++) bandPat[i] = 1'b1;
      end
      if (($urandom % 4) == 0) begin
        st = int'($urandom % len);
        ceilPat[st] = 1'b1;
        bandPat[st] = 1'b0;
      end
      eLow = ($urandom % 8) != 0;
      xLow = ($urandom % 8) != 0;
      runWin(len, eLow, xLow, "R3 R4 R5 random window");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule